// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler with Register Scoreboard

This block sits between the decoder and a single execution unit of a scalar four-stage pipeline (fetch, decode/issue, execute, write back). Decoded instructions arrive one per cycle in program order. Each carries an opcode, a destination register, a register source A, and a second source that is either a register or a small immediate. Every accepted instruction receives a sequence tag. It then waits in a four-entry holding queue until its operands are available. Results are tracked per register with a busy bit and a producer tag.

Each cycle the oldest holding entry whose operands are ready launches into execute. Arithmetic and logic operations spend one cycle there. A load spends five cycles there, reading a fixed-latency memory port in its last execute cycle. A consumer stalled behind a slow load does not block younger independent work. A single write-back port returns one result per cycle to the register file and to any waiting entries.

The block reports the launch of each instruction and its write-back, each with its tag, so the caller can rebuild the pipeline timing table.

Top module: `sched_ooo_top`

## Requirements
- R1: After reset, dec_ready is 1 and ex_valid, wb_valid and mem_valid are 0. All 16 registers read as zero and none is pending.
- R2: An arithmetic or logic instruction whose operands are ready is accepted in cycle n. It launches (ex_valid) in cycle n+1 and writes back (wb_valid) in cycle n+2.
- R3: A LOAD launched in cycle L drives mem_valid and mem_addr (the value of source A) in cycle L+4. It writes back mem_rdata of that cycle in cycle L+5.
- R4: An instruction that reads a pending register launches no earlier than the cycle after that producer's write back. It uses the produced value.
- R5: At most one instruction launches per cycle. Among ready queued entries the oldest goes first, so younger independent instructions bypass a stalled one.
- R6: Opcode codes are 0 ADD, 1 SUB, 2 AND, 3 OR, 4 SRL, 5 LOAD. SRL shifts right logically by the low 5 bits of source B. An immediate (dec_imm_sel=1) is zero-extended to 32 bits.
- R7: No arithmetic or logic instruction launches in a cycle where mem_valid is 1, so two results never compete for write back.
- R8: A register source that is ready at decode is captured then. A younger write to that register cannot change the value the waiting instruction uses.
- R9: When a younger instruction targets the same register, the older write is dropped. Later readers see the younger value.
- R10: When four entries are queued, dec_ready is 0 until an entry launches.
- R11: Tags are assigned at acceptance, starting at 0 after reset and incrementing by one modulo 16. ex_tag and wb_tag carry the instruction's tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_ready | output | 1 | Scheduler can accept an instruction this cycle |
| dec_op | input | 3 | Opcode (R6 encoding) |
| dec_rd | input | 4 | Destination register |
| dec_rs1 | input | 4 | Source A register (address for LOAD) |
| dec_rs2 | input | 4 | Source B register |
| dec_imm_sel | input | 1 | Source B is the immediate |
| dec_imm | input | 8 | Immediate value |
| ex_valid | output | 1 | An instruction enters execute this cycle |
| ex_tag | output | 4 | Tag of the launching instruction |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_tag | output | 4 | Tag of the writing instruction |
| wb_rd | output | 4 | Destination of the result |
| wb_data | output | 32 | Result value |
| mem_valid | output | 1 | Load in its final execute cycle |
| mem_addr | output | 32 | Load address |
| mem_rdata | input | 32 | Load data, same cycle as mem_addr |

## Verification
The properties assume that mem_rdata is a pure function of mem_addr in the same cycle. They also assume that dec_valid and the decode fields are held stable by the caller until dec_ready is seen. The stimulus meets both assumptions: the memory model is a combinational formula, and every instruction is presented at a falling edge and held until an accepting rising edge. The properties also rely on fewer than 16 instructions being in flight, so that tags stay unique. The holding queue and the five-cycle load path keep this true, and no scenario exceeds ten outstanding instructions.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int NREG   = 16;
    localparam int XLEN   = 32;
    localparam int IMM_W  = 8;
    localparam int TAG_W  = 4;
    localparam int NENT   = 4;
    localparam int LD_LAT = 5;
    localparam int OP_W   = 3;

    localparam int RIDX_W = $clog2(NREG);
    localparam int IDX_W  = $clog2(NENT);
    localparam int CNT_W  = $clog2(NENT + 1);
    localparam int LD_STG = LD_LAT - 1;
    localparam int SH_W   = $clog2(XLEN);

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_SRL  = 3'd4,
        OP_LOAD = 3'd5
    } op_e;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [XLEN-1:0]   val;
    } src_t;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        op_e               op;
        logic [RIDX_W-1:0] rd;
        logic              a_rdy;
        logic [TAG_W-1:0]  a_tag;
        logic [XLEN-1:0]   a_val;
        logic              b_rdy;
        logic [TAG_W-1:0]  b_tag;
        logic [XLEN-1:0]   b_val;
    } hq_ent_t;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [RIDX_W-1:0] rd;
        logic [XLEN-1:0]   data;
    } wb_t;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [RIDX_W-1:0] rd;
        logic [XLEN-1:0]   addr;
    } lp_t;
endpackage

// File: rtl/sched_regstat.sv
module sched_regstat
    import sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] rd_a,
    input  logic [RIDX_W-1:0] rd_b,
    output src_t              src_a,
    output src_t              src_b,
    input  logic              alloc_en,
    input  logic [RIDX_W-1:0] alloc_rd,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  wb_t               wb
);
    typedef struct packed {
        logic [NREG-1:0]            busy;
        logic [NREG-1:0][TAG_W-1:0] ptag;
        logic [NREG-1:0][XLEN-1:0]  rf;
    } st_t;

    st_t st_d, st_q;

    // Read with same-cycle forwarding from the write-back port.
    function automatic src_t lookup(input st_t s, input logic [RIDX_W-1:0] idx, input wb_t w);
        src_t r;
        r.rdy = !s.busy[idx];
        r.tag = s.ptag[idx];
        r.val = s.rf[idx];
        if (s.busy[idx] && w.valid && (s.ptag[idx] == w.tag)) begin
            r.rdy = 1'b1;
            r.val = w.data;
        end
        return r;
    endfunction

    assign src_a = lookup(st_q, rd_a, wb);
    assign src_b = lookup(st_q, rd_b, wb);

    always_comb begin
        st_d = st_q;
        // Only the newest producer of a register may retire it (WAW).
        if (wb.valid && st_q.busy[wb.rd] && (st_q.ptag[wb.rd] == wb.tag)) begin
            st_d.busy[wb.rd] = 1'b0;
            st_d.rf[wb.rd]   = wb.data;
        end
        if (alloc_en) begin
            st_d.busy[alloc_rd] = 1'b1;
            st_d.ptag[alloc_rd] = alloc_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sched_holdq.sv
module sched_holdq
    import sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  hq_ent_t           push_ent,
    input  wb_t               wb,
    input  logic              alu_block,
    output logic              full,
    output logic [CNT_W-1:0]  cnt,
    output logic              iss_valid,
    output logic [TAG_W-1:0]  iss_tag,
    output op_e               iss_op,
    output logic [RIDX_W-1:0] iss_rd,
    output logic [XLEN-1:0]   iss_a,
    output logic [XLEN-1:0]   iss_b
);
    typedef struct packed {
        hq_ent_t [NENT-1:0] ent;
        logic [CNT_W-1:0]   cnt;
    } st_t;

    st_t st_d, st_q;
    logic               found;
    logic [IDX_W-1:0]   sel;
    logic [CNT_W-1:0]   cnt_after;
    hq_ent_t [NENT-1:0] woken;
    hq_ent_t [NENT-1:0] nxt;

    always_comb begin
        st_d  = st_q;
        found = 1'b0;
        sel   = '0;
        // Index 0 is always the oldest entry: first ready wins.
        for (int i = 0; i < NENT; i++) begin
            if (!found && st_q.ent[i].valid && st_q.ent[i].a_rdy && st_q.ent[i].b_rdy &&
                !(alu_block && (st_q.ent[i].op != OP_LOAD))) begin
                found = 1'b1;
                sel   = IDX_W'(i);
            end
        end

        woken = st_q.ent;
        for (int i = 0; i < NENT; i++) begin
            if (wb.valid && woken[i].valid && !woken[i].a_rdy && (woken[i].a_tag == wb.tag)) begin
                woken[i].a_rdy = 1'b1;
                woken[i].a_val = wb.data;
            end
            if (wb.valid && woken[i].valid && !woken[i].b_rdy && (woken[i].b_tag == wb.tag)) begin
                woken[i].b_rdy = 1'b1;
                woken[i].b_val = wb.data;
            end
        end

        nxt = woken;
        if (found) begin
            for (int i = 0; i < NENT - 1; i++) begin
                if (IDX_W'(i) >= sel) nxt[i] = woken[i + 1];
            end
            nxt[NENT-1] = '0;
        end

        cnt_after = st_q.cnt - CNT_W'(found);
        if (push) nxt[cnt_after[IDX_W-1:0]] = push_ent;

        st_d.ent = nxt;
        st_d.cnt = cnt_after + CNT_W'(push);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full      = (st_q.cnt == CNT_W'(NENT));
    assign cnt       = st_q.cnt;
    assign iss_valid = found;
    assign iss_tag   = st_q.ent[sel].tag;
    assign iss_op    = st_q.ent[sel].op;
    assign iss_rd    = st_q.ent[sel].rd;
    assign iss_a     = st_q.ent[sel].a_val;
    assign iss_b     = st_q.ent[sel].b_val;
endmodule

// File: rtl/sched_exec.sv
module sched_exec
    import sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [TAG_W-1:0]  iss_tag,
    input  op_e               iss_op,
    input  logic [RIDX_W-1:0] iss_rd,
    input  logic [XLEN-1:0]   iss_a,
    input  logic [XLEN-1:0]   iss_b,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              alu_block,
    output logic              mem_valid,
    output logic [XLEN-1:0]   mem_addr,
    output wb_t               wb
);
    typedef struct packed {
        lp_t [LD_STG-1:0] lp;
        wb_t              wb;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [XLEN-1:0] alu(input op_e op, input logic [XLEN-1:0] a,
                                            input logic [XLEN-1:0] b);
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_AND:  return a & b;
            OP_OR:   return a | b;
            OP_SRL:  return a >> b[SH_W-1:0];
            default: return '0;
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        st_d.lp[0].valid = iss_valid && (iss_op == OP_LOAD);
        st_d.lp[0].tag   = iss_tag;
        st_d.lp[0].rd    = iss_rd;
        st_d.lp[0].addr  = iss_a;
        for (int k = 1; k < LD_STG; k++) st_d.lp[k] = st_q.lp[k-1];

        st_d.wb = '0;
        if (st_q.lp[LD_STG-1].valid) begin
            st_d.wb.valid = 1'b1;
            st_d.wb.tag   = st_q.lp[LD_STG-1].tag;
            st_d.wb.rd    = st_q.lp[LD_STG-1].rd;
            st_d.wb.data  = mem_rdata;
        end else if (iss_valid && (iss_op != OP_LOAD)) begin
            st_d.wb.valid = 1'b1;
            st_d.wb.tag   = iss_tag;
            st_d.wb.rd    = iss_rd;
            st_d.wb.data  = alu(iss_op, iss_a, iss_b);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alu_block = st_q.lp[LD_STG-1].valid;
    assign mem_valid = st_q.lp[LD_STG-1].valid;
    assign mem_addr  = st_q.lp[LD_STG-1].addr;
    assign wb        = st_q.wb;
endmodule

// File: rtl/sched_ooo_top.sv
module sched_ooo_top
    import sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    output logic              dec_ready,
    input  logic [OP_W-1:0]   dec_op,
    input  logic [RIDX_W-1:0] dec_rd,
    input  logic [RIDX_W-1:0] dec_rs1,
    input  logic [RIDX_W-1:0] dec_rs2,
    input  logic              dec_imm_sel,
    input  logic [IMM_W-1:0]  dec_imm,
    output logic              ex_valid,
    output logic [TAG_W-1:0]  ex_tag,
    output logic              wb_valid,
    output logic [TAG_W-1:0]  wb_tag,
    output logic [RIDX_W-1:0] wb_rd,
    output logic [XLEN-1:0]   wb_data,
    output logic              mem_valid,
    output logic [XLEN-1:0]   mem_addr,
    input  logic [XLEN-1:0]   mem_rdata
);
    typedef struct packed {
        logic [TAG_W-1:0] seq;
    } st_t;

    st_t               st_d, st_q;
    logic              full;
    logic              accept;
    logic [CNT_W-1:0]  q_cnt;
    src_t              a_src, b_src;
    hq_ent_t           push_ent;
    wb_t               wb;
    logic              alu_block;
    logic              iss_valid;
    logic [TAG_W-1:0]  iss_tag;
    op_e               iss_op;
    logic [RIDX_W-1:0] iss_rd;
    logic [XLEN-1:0]   iss_a, iss_b;
    logic              iss_load;

    assign dec_ready = !full;
    assign accept    = dec_valid && !full;

    always_comb begin
        st_d = st_q;
        if (accept) st_d.seq = st_q.seq + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Build the queue entry, capturing operands that are ready now (WAR).
    always_comb begin
        push_ent       = '0;
        push_ent.valid = 1'b1;
        push_ent.tag   = st_q.seq;
        push_ent.op    = op_e'(dec_op);
        push_ent.rd    = dec_rd;
        push_ent.a_rdy = a_src.rdy;
        push_ent.a_tag = a_src.tag;
        push_ent.a_val = a_src.val;
        if (dec_imm_sel || (op_e'(dec_op) == OP_LOAD)) begin
            push_ent.b_rdy = 1'b1;
            push_ent.b_val = XLEN'(dec_imm);
        end else begin
            push_ent.b_rdy = b_src.rdy;
            push_ent.b_tag = b_src.tag;
            push_ent.b_val = b_src.val;
        end
    end

    sched_regstat u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a      (dec_rs1),
        .rd_b      (dec_rs2),
        .src_a     (a_src),
        .src_b     (b_src),
        .alloc_en  (accept),
        .alloc_rd  (dec_rd),
        .alloc_tag (st_q.seq),
        .wb        (wb)
    );

    sched_holdq u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_ent  (push_ent),
        .wb        (wb),
        .alu_block (alu_block),
        .full      (full),
        .cnt       (q_cnt),
        .iss_valid (iss_valid),
        .iss_tag   (iss_tag),
        .iss_op    (iss_op),
        .iss_rd    (iss_rd),
        .iss_a     (iss_a),
        .iss_b     (iss_b)
    );

    sched_exec u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid),
        .iss_tag   (iss_tag),
        .iss_op    (iss_op),
        .iss_rd    (iss_rd),
        .iss_a     (iss_a),
        .iss_b     (iss_b),
        .mem_rdata (mem_rdata),
        .alu_block (alu_block),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .wb        (wb)
    );

    assign iss_load = iss_valid && (iss_op == OP_LOAD);
    assign ex_valid = iss_valid;
    assign ex_tag   = iss_tag;
    assign wb_valid = wb.valid;
    assign wb_tag   = wb.tag;
    assign wb_rd    = wb.rd;
    assign wb_data  = wb.data;
endmodule

// File: rtl/sched_ooo_chk.sv
module sched_ooo_chk #(
    parameter int TAG_W = 4,
    parameter int XLEN  = 32,
    parameter int CNT_W = 3,
    parameter int NENT  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dec_ready,
    input logic             ex_valid,
    input logic             iss_load,
    input logic [TAG_W-1:0] ex_tag,
    input logic             wb_valid,
    input logic [TAG_W-1:0] wb_tag,
    input logic [XLEN-1:0]  wb_data,
    input logic             mem_valid,
    input logic [XLEN-1:0]  mem_rdata,
    input logic [CNT_W-1:0] q_cnt
);
    // R2: a single-cycle op reaches write back on the next cycle with its tag
    a_r2_alu_wb_next: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !iss_load) |=> (wb_valid && (wb_tag == $past(ex_tag))));

    // R3: load data seen on the memory port is what gets written back
    a_r3_load_data: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |=> (wb_valid && (wb_data == $past(mem_rdata))));

    // R7: no single-cycle op launches while a load holds the write-back slot
    a_r7_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !(ex_valid && !iss_load));

    // R10: a full queue refuses decode
    a_r10_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cnt == CNT_W'(NENT)) |-> !dec_ready);

    // R10: occupancy never passes capacity
    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt <= CNT_W'(NENT));
endmodule

bind sched_ooo_top sched_ooo_chk #(
    .TAG_W (sched_pkg::TAG_W),
    .XLEN  (sched_pkg::XLEN),
    .CNT_W (sched_pkg::CNT_W),
    .NENT  (sched_pkg::NENT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_ready (dec_ready),
    .ex_valid  (ex_valid),
    .iss_load  (iss_load),
    .ex_tag    (ex_tag),
    .wb_valid  (wb_valid),
    .wb_tag    (wb_tag),
    .wb_data   (wb_data),
    .mem_valid (mem_valid),
    .mem_rdata (mem_rdata),
    .q_cnt     (q_cnt)
);

// File: tb/sched_ooo_top_tb.sv
module sched_ooo_top_tb;
    localparam int C_ADD = 0, C_SUB = 1, C_AND = 2, C_OR = 3, C_SRL = 4, C_LD = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic        dec_ready;
    logic [2:0]  dec_op = '0;
    logic [3:0]  dec_rd = '0, dec_rs1 = '0, dec_rs2 = '0;
    logic        dec_imm_sel = 1'b0;
    logic [7:0]  dec_imm = '0;
    logic        ex_valid, wb_valid, mem_valid;
    logic [3:0]  ex_tag, wb_tag, wb_rd;
    logic [31:0] wb_data, mem_addr, mem_rdata;

    int total = 0, bad = 0, cyc = 0, next_tag = 0;
    bit finished = 0;
    int ex_at [16];
    int wb_at [16];
    logic [31:0] wb_dat [16];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign mem_rdata = mem_addr * 32'd3 + 32'h100;

    sched_ooo_top u_dut (.*);

    always @(negedge clk) begin
        if (ex_valid) ex_at[ex_tag] = cyc;
        if (wb_valid) begin
            wb_at[wb_tag]  = cyc;
            wb_dat[wb_tag] = wb_data;
        end
    end

    always @(negedge clk) begin
        if (cyc > 20000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog: act=%0d exp<20000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input int op, input int rd, input int rs1, input int rs2,
                         input bit imm_sel, input int imm, output int tag, output int acc);
        dec_valid = 1'b1; dec_op = 3'(op); dec_rd = 4'(rd); dec_rs1 = 4'(rs1);
        dec_rs2 = 4'(rs2); dec_imm_sel = imm_sel; dec_imm = 8'(imm);
        while (!dec_ready) @(negedge clk);
        acc = cyc;
        tag = next_tag;
        next_tag = (next_tag + 1) % 16;
        ex_at[tag] = -1; wb_at[tag] = -1;
        @(negedge clk);
        dec_valid = 1'b0;
    endtask

    task automatic wait_done(input int tag);
        while (wb_at[tag] < 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 dec_ready", 32'(dec_ready), 1);
        chk("R1 ex_valid", 32'(ex_valid), 0);
        chk("R1 wb_valid", 32'(wb_valid), 0);
        chk("R1 mem_valid", 32'(mem_valid), 0);
    endtask

    task automatic t_seed_and_ref();
        int t, a, base;
        int tg [11];
        int ac [11];
        int e_dec [11] = '{1, 2, 3, 4, 5, 6, 7, 8, 10, 11, 12};
        int e_ex  [11] = '{2, 4, 5, 10, 6, 9, 11, 12, 13, 19, 14};
        int e_wb  [11] = '{3, 9, 6, 11, 7, 10, 12, 13, 18, 20, 15};
        logic [31:0] e_dat [11] = '{32'd14, 32'd298, 32'd2, 32'd300, 32'd0, 32'h30,
                                    32'hFFFFFFDE, 32'd307, 32'd154, 32'd146, 32'd0};
        // R1: registers reset to zero, so OR with R0 seeds plain immediates
        issue(C_OR, 1, 0, 0, 1, 5, t, a);
        chk("R1 zero reg seed", 32'(t), 0);
        issue(C_OR, 2, 0, 0, 1, 9, t, a);
        issue(C_OR, 4, 0, 0, 1, 8'h30, t, a);
        issue(C_OR, 5, 0, 0, 1, 8'h22, t, a);
        issue(C_OR, 10, 0, 0, 1, 7, t, a);
        wait_done(t);
        chk("R1 seed value", wb_dat[t], 7);
        issue(C_ADD, 3, 1, 2, 0, 0, tg[0], ac[0]);
        issue(C_LD, 6, 3, 0, 0, 0, tg[1], ac[1]);
        issue(C_AND, 7, 5, 0, 1, 3, tg[2], ac[2]);
        issue(C_ADD, 1, 6, 7, 0, 0, tg[3], ac[3]);
        issue(C_SRL, 7, 0, 0, 1, 8, tg[4], ac[4]);
        issue(C_OR, 2, 4, 7, 0, 0, tg[5], ac[5]);
        issue(C_SUB, 5, 3, 4, 0, 0, tg[6], ac[6]);
        issue(C_ADD, 0, 1, 10, 0, 0, tg[7], ac[7]);
        issue(C_LD, 6, 5, 0, 0, 0, tg[8], ac[8]);
        issue(C_SUB, 2, 1, 6, 0, 0, tg[9], ac[9]);
        issue(C_AND, 3, 7, 0, 1, 15, tg[10], ac[10]);
        wait_done(tg[9]);
        base = ac[0] - 1;
        chk("R11 tag sequence", 32'(tg[0]), 5);
        for (int i = 0; i < 11; i++) begin
            // R10 decode stall at slot 8; R5 bypass order; R4 dependency waits;
            // R3 load timing and R7 write-back slot conflicts all shape this table
            chk($sformatf("R10 decode cycle i%0d", i), 32'(ac[i] - base), 32'(e_dec[i]));
            chk($sformatf("R5 execute cycle i%0d", i), 32'(ex_at[tg[i]] - base), 32'(e_ex[i]));
            chk($sformatf("R4 writeback cycle i%0d", i), 32'(wb_at[tg[i]] - base), 32'(e_wb[i]));
            chk($sformatf("R6 result i%0d", i), wb_dat[tg[i]], e_dat[i]);
        end
        chk("R3 load exec 4", 32'(ex_at[tg[1]] - base), 4);
        chk("R7 OR delayed past load slot", 32'(ex_at[tg[5]] - base), 9);
    endtask

    task automatic t_alu_dep();
        int t1, a1, t2, a2;
        issue(C_OR, 12, 14, 0, 1, 8'hF0, t1, a1);
        issue(C_SRL, 13, 12, 0, 1, 8'h24, t2, a2);
        wait_done(t2);
        chk("R2 launch n+1", 32'(ex_at[t1] - a1), 1);
        chk("R2 writeback n+2", 32'(wb_at[t1] - a1), 2);
        chk("R4 consumer after producer wb", 32'(ex_at[t2] - wb_at[t1]), 1);
        chk("R6 SRL low five bits", wb_dat[t2], 32'hF);
    endtask

    task automatic t_war();
        int t, a, tl, al, tc, acn, tw, aw;
        issue(C_OR, 0, 14, 0, 1, 8'h10, t, a);
        issue(C_OR, 2, 14, 0, 1, 8'h21, t, a);
        wait_done(t);
        issue(C_LD, 8, 0, 0, 0, 0, tl, al);
        issue(C_ADD, 9, 8, 2, 0, 0, tc, acn);
        issue(C_OR, 2, 14, 0, 1, 8'h55, tw, aw);
        wait_done(tc);
        chk("R8 held op keeps old R2", wb_dat[tc], 32'd337);
        chk("R5 younger writer launched first", 32'(ex_at[tw] < ex_at[tc]), 1);
        chk("R3 load wb at L+5", 32'(wb_at[tl] - ex_at[tl]), 5);
    endtask

    task automatic t_waw();
        int tl, al, to, ao, t1, a1, t2, a2;
        issue(C_LD, 8, 14, 0, 0, 0, tl, al);
        issue(C_OR, 8, 14, 0, 1, 8'h11, to, ao);
        issue(C_ADD, 11, 8, 0, 1, 0, t1, a1);
        wait_done(tl);
        issue(C_ADD, 9, 8, 0, 1, 0, t2, a2);
        wait_done(t2);
        chk("R3 load data", wb_dat[tl], 32'h100);
        chk("R9 reader before old wb", wb_dat[t1], 32'h11);
        chk("R9 reader after old wb", wb_dat[t2], 32'h11);
    endtask

    task automatic t_full();
        int tl, al, t5, a5;
        int td [4];
        int ad [4];
        issue(C_LD, 8, 14, 0, 0, 0, tl, al);
        for (int k = 0; k < 4; k++) issue(C_ADD, 9 + k, 8, 0, 1, k + 1, td[k], ad[k]);
        chk("R10 stall visible", 32'(dec_ready), 0);
        issue(C_OR, 13, 14, 0, 1, 5, t5, a5);
        wait_done(t5);
        chk("R10 fifth accepted at n+8", 32'(a5 - al), 8);
        for (int k = 0; k < 4; k++) begin
            chk($sformatf("R5 oldest first d%0d", k), 32'(ex_at[td[k]] - al), 32'(7 + k));
            chk($sformatf("R6 add imm d%0d", k), wb_dat[td[k]], 32'h100 + 32'(k + 1));
        end
        chk("R5 younger ready waits for older", 32'(ex_at[t5] - al), 11);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin ex_at[i] = -1; wb_at[i] = -1; wb_dat[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seed_and_ref();
        t_alu_dep();
        t_war();
        t_waw();
        t_full();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule